// File: doc/BRIEF.md
# Dual 512-bit Permutation Round Engine

This block applies one of two fixed 512-bit permutations, P or Q, to a state of 64 bytes laid out as an 8 by 8 grid. Each permutation consists of ten rounds, and the engine computes one round per clock. Each round goes through four stages in a fixed order: a round-dependent constant is XORed in, every byte passes through the AES forward S-box, each row is rotated by a mode-specific byte distance, and each column is multiplied by a circulant matrix over GF(2^8). The datapath is the same for both permutations. Only the constant pattern and the row rotations depend on the select bit.

A caller raises `start` for one cycle while the engine is idle, with the input state and the P/Q select. The engine stays busy for ten cycles, then pulses `done` for one cycle. The permuted state is available on `state_out` from that cycle and stays there until the next accepted start. Message padding, chaining and feed-forward belong to the surrounding logic. One instance can be used for both P and Q in turn, or two instances can run side by side.

Top module: `perm_engine`

## Requirements
- R1: After reset, `busy` and `done` are low and `state_out` is all zeros.
- R2: A `start` sampled high while idle loads `state_in` and `sel_q` (0 selects P, 1 selects Q) and raises `busy` at that same clock edge.
- R3: Exactly ROUNDS (default 10) rounds are applied, with round index 0 first. `done` is high for exactly one cycle. It rises, and `busy` falls, at the ROUNDS-th clock edge after the edge that accepted `start`.
- R4: A `start` sampled while `busy` is high has no effect: neither the result nor the completion timing changes.
- R5: In P mode, row 0 byte c is XORed with (c<<4) XOR i, where i is the round index. No other row receives a constant.
- R6: In Q mode, every byte of rows 0 to 6 is XORed with 0xFF, and row 7 byte c is XORed with 0xFF XOR (c<<4) XOR i.
- R7: After the constant, each of the 64 bytes is replaced by its AES forward S-box value (for example 0x00 becomes 0x63 and 0x53 becomes 0xED).
- R8: Row rotation sets new byte c of row r to old byte (c+s) mod 8. In P mode s equals r. In Q mode s for rows 0 to 7 is 1,3,5,7,0,2,4,6.
- R9: Column mixing sets new row i of a column to the XOR over k of coef[k]·a[(i+k) mod 8]. The coefficients for k=0..7 are 02,02,03,04,05,03,05,07, and products are taken modulo x^8+x^4+x^3+x+1.
- R10: Between completion and the next accepted start, `state_out` holds the result unchanged, whatever `state_in` and `sel_q` do.
- R11: Row r, column c of the state is bits [64r+8c+7 : 64r+8c] of both `state_in` and `state_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new permutation; honoured only while idle |
| sel_q | input | 1 | Permutation select captured at start: 0 = P, 1 = Q |
| state_in | input | 512 | Input state, row-major, byte c of row r at bit 64r+8c |
| busy | output | 1 | High while rounds are running |
| done | output | 1 | One-cycle completion pulse |
| state_out | output | 512 | State register; valid result from `done` onward |

## Verification
The hardest case to reach is a `start` that arrives in the middle of a run and carries a different state and the opposite select. Only an engine that wrongly reloads, or wrongly latches the new mode, would show a different result. The bench injects such a request on the third busy cycle of selected runs. It then requires both the result and the ten-cycle completion time to match an undisturbed reference. The remaining runs sweep structured states (all-zero, all-ones, ascending bytes) and a long pseudo-random series through both P and Q. Each result is compared with a bench model that finds S-box values by inverse search and does field multiplication by shift-and-add.

// File: rtl/perm_pkg.sv
package perm_pkg;

   localparam int ROWS    = 8;
   localparam int COLS    = 8;
   localparam int BYTE_W  = 8;
   localparam int STATE_W = ROWS * COLS * BYTE_W;

   typedef logic [ROWS-1:0][COLS-1:0][BYTE_W-1:0] grid_t;
   typedef logic [ROWS-1:0][BYTE_W-1:0]            column_t;

   // multiply by x modulo x^8+x^4+x^3+x+1
   function automatic logic [7:0] xt(input logic [7:0] a);
      return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
   endfunction

   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] acc;
      logic [7:0] sh;
      acc = 8'h00;
      sh  = a;
      for (int n = 0; n < 8; n++) begin
         if (b[n]) acc = acc ^ sh;
         sh = xt(sh);
      end
      return acc;
   endfunction

   // forward substitution: inverse as x^254, then affine map
   function automatic logic [7:0] sbox(input logic [7:0] x);
      logic [7:0] pw;
      logic [7:0] inv;
      pw  = x;
      inv = 8'h01;
      for (int n = 0; n < 7; n++) begin
         pw  = gf_mul(pw, pw);
         inv = gf_mul(inv, pw);
      end
      if (x == 8'h00) inv = 8'h00;
      return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                 ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
   endfunction

   // byte rotation distance of row r for each mode
   function automatic int row_shift(input bit q_mode, input int r);
      if (!q_mode) return r;
      return (r < 4) ? (2 * r + 1) : (2 * r - 8);
   endfunction

   // circulant coefficient k applied to one byte
   function automatic logic [7:0] mul_coef(input int k, input logic [7:0] a);
      logic [7:0] d2;
      logic [7:0] d4;
      d2 = xt(a);
      d4 = xt(d2);
      case (k)
         0, 1:    return d2;
         2, 5:    return d2 ^ a;
         3:       return d4;
         4, 6:    return d4 ^ a;
         default: return d4 ^ d2 ^ a;
      endcase
   endfunction

endpackage

// File: rtl/perm_mix_col.sv
module perm_mix_col
   import perm_pkg::*;
(
   input  column_t col_in,
   output column_t col_out
);

   always_comb begin
      for (int i = 0; i < ROWS; i++) begin
         logic [7:0] acc;
         acc = 8'h00;
         for (int k = 0; k < ROWS; k++) begin
            acc = acc ^ mul_coef(k, col_in[(i + k) % ROWS]);
         end
         col_out[i] = acc;
      end
   end

endmodule

// File: rtl/perm_round.sv
module perm_round
   import perm_pkg::*;
(
   input  grid_t      cur,
   input  logic [3:0] idx,
   input  logic       is_q,
   output grid_t      nxt
);

   grid_t ac;
   grid_t sb;
   grid_t sh;

   // constant injection
   always_comb begin
      for (int r = 0; r < ROWS; r++) begin
         for (int c = 0; c < COLS; c++) begin
            logic [7:0] pat;
            pat = 8'(c << 4) ^ {4'h0, idx};
            if (is_q)
               ac[r][c] = cur[r][c] ^ ((r == ROWS - 1) ? ~pat : 8'hff);
            else
               ac[r][c] = cur[r][c] ^ ((r == 0) ? pat : 8'h00);
         end
      end
   end

   for (genvar gr = 0; gr < ROWS; gr++) begin : g_row
      for (genvar gc = 0; gc < COLS; gc++) begin : g_byte
         localparam int SRC_P = (gc + row_shift(1'b0, gr)) % COLS;
         localparam int SRC_Q = (gc + row_shift(1'b1, gr)) % COLS;
         assign sb[gr][gc] = sbox(ac[gr][gc]);
         assign sh[gr][gc] = is_q ? sb[gr][SRC_Q] : sb[gr][SRC_P];
      end
   end

   for (genvar gc = 0; gc < COLS; gc++) begin : g_col
      column_t col_i;
      column_t col_o;
      for (genvar gr = 0; gr < ROWS; gr++) begin : g_tap
         assign col_i[gr]   = sh[gr][gc];
         assign nxt[gr][gc] = col_o[gr];
      end
      perm_mix_col u_mix (
         .col_in  (col_i),
         .col_out (col_o)
      );
   end

endmodule

// File: rtl/perm_ctrl.sv
module perm_ctrl #(
   parameter int ROUNDS = 10,
   parameter int CW     = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          sel_q,
   output logic          load,
   output logic          step,
   output logic          mode,
   output logic [CW-1:0] rnd,
   output logic          busy,
   output logic          done
);

   localparam logic [CW-1:0] LAST = CW'(ROUNDS - 1);

   assign load = start && !busy;
   assign step = busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         rnd  <= '0;
         mode <= 1'b0;
      end else begin
         done <= 1'b0;
         if (load) begin
            busy <= 1'b1;
            rnd  <= '0;
            mode <= sel_q;
         end else if (busy) begin
            if (rnd == LAST) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               rnd <= rnd + CW'(1);
            end
         end
      end
   end

   // R2
   start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && rnd == '0 && mode == $past(sel_q)));

   // R3
   round_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rnd != LAST) |=> (busy && rnd == $past(rnd) + CW'(1)));

   // R3
   finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rnd == LAST) |=> (done && !busy));

   // R3
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R4
   busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(mode));

endmodule

// File: rtl/perm_engine.sv
module perm_engine
   import perm_pkg::*;
#(
   parameter int ROUNDS = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               sel_q,
   input  logic [STATE_W-1:0] state_in,
   output logic               busy,
   output logic               done,
   output logic [STATE_W-1:0] state_out
);

   localparam int CW = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;

   if (ROUNDS < 1 || ROUNDS > 16) begin : g_bad_rounds
      $error("perm_engine: ROUNDS must lie in 1..16 so the index fits a nibble");
   end

   logic          load;
   logic          step;
   logic          mode;
   logic [CW-1:0] rnd;
   grid_t         state_q;
   grid_t         round_out;

   perm_ctrl #(
      .ROUNDS (ROUNDS),
      .CW     (CW)
   ) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .sel_q (sel_q),
      .load  (load),
      .step  (step),
      .mode  (mode),
      .rnd   (rnd),
      .busy  (busy),
      .done  (done)
   );

   perm_round u_round (
      .cur  (state_q),
      .idx  (4'(rnd)),
      .is_q (mode),
      .nxt  (round_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= '0;
      else if (load)
         state_q <= grid_t'(state_in);
      else if (step)
         state_q <= round_out;
   end

   assign state_out = STATE_W'(state_q);

   // R10
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(state_q));

   // R2
   load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (state_q == grid_t'($past(state_in))));

endmodule

// File: tb/perm_engine_bench.sv
module perm_engine_bench;
   import perm_pkg::*;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start = 1'b0;
   logic               sel_q = 1'b0;
   logic [STATE_W-1:0] din = '0;
   logic               busy;
   logic               done;
   logic [STATE_W-1:0] dout;

   int checks = 0;
   int errors = 0;
   logic [7:0] sbt [256];
   int qs [8]   = '{1, 3, 5, 7, 0, 2, 4, 6};
   int coef [8] = '{2, 2, 3, 4, 5, 3, 5, 7};

   always #10 clk = ~clk;

   perm_engine u_perm_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .sel_q     (sel_q),
      .state_in  (din),
      .busy      (busy),
      .done      (done),
      .state_out (dout)
   );

   function automatic logic [7:0] m2(input logic [7:0] a);
      return (a << 1) ^ (a[7] ? 8'h1b : 8'h00);
   endfunction

   function automatic logic [7:0] mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] p = 0;
      logic [7:0] x = a;
      logic [7:0] y = b;
      while (y != 0) begin
         if (y[0]) p ^= x;
         x = m2(x);
         y = y >> 1;
      end
      return p;
   endfunction

   function automatic logic [STATE_W-1:0] ref_perm(input logic [STATE_W-1:0] s, input bit q);
      logic [7:0] m [8][8];
      logic [7:0] t [8][8];
      logic [STATE_W-1:0] o;
      for (int r = 0; r < 8; r++)
         for (int c = 0; c < 8; c++) m[r][c] = s[64*r + 8*c +: 8];
      for (int i = 0; i < 10; i++) begin
         for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) begin
               logic [7:0] k = 8'h00;
               if (!q && r == 0) k = 8'((c << 4) ^ i);
               if (q) k = (r == 7) ? 8'(8'hff ^ (c << 4) ^ i) : 8'hff;
               m[r][c] = sbt[m[r][c] ^ k];
            end
         for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) t[r][c] = m[r][(c + (q ? qs[r] : r)) % 8];
         for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) begin
               logic [7:0] acc = 8'h00;
               for (int k = 0; k < 8; k++) acc ^= mul(8'(coef[k]), t[(r + k) % 8][c]);
               m[r][c] = acc;
            end
      end
      for (int r = 0; r < 8; r++)
         for (int c = 0; c < 8; c++) o[64*r + 8*c +: 8] = m[r][c];
      return o;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [STATE_W-1:0] act, input logic [STATE_W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // one permutation; inject = stray start with other data mid-run
   task automatic run_perm(input logic [STATE_W-1:0] s, input bit q, input bit inject,
                           output logic [STATE_W-1:0] res);
      int n = 0;
      @(negedge clk);
      din = s; sel_q = q; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R2", "busy after start", STATE_W'(busy), 1);
      while (!done && n < 40) begin
         @(negedge clk);
         n++;
         if (inject && n == 3) begin start = 1'b1; sel_q = ~q; din = ~s; end
         if (inject && n == 4) start = 1'b0;
      end
      check(n == 10, inject ? "R4" : "R3", "cycles to done", STATE_W'(n), 10);
      check(busy == 1'b0, "R3", "busy at done", STATE_W'(busy), 0);
      res = dout;
      @(negedge clk);
      check(done == 1'b0, "R3", "done width", STATE_W'(done), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R3 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [STATE_W-1:0] v;
      logic [STATE_W-1:0] got;
      logic [STATE_W-1:0] exp;
      logic [63:0] lf = 64'h0123_4567_89ab_cdef;

      // reference S-box by inverse search
      for (int x = 0; x < 256; x++) begin
         logic [7:0] inv = 8'h00;
         logic [7:0] sv;
         for (int y = 1; y < 256; y++) if (mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
         for (int b = 0; b < 8; b++)
            sv[b] = inv[b] ^ inv[(b+4)%8] ^ inv[(b+5)%8] ^ inv[(b+6)%8] ^ inv[(b+7)%8];
         sbt[x] = sv ^ 8'h63;
      end
      check(sbt[0] == 8'h63, "R7", "model sbox 00", STATE_W'(sbt[0]), 'h63);
      check(sbt[1] == 8'h7c, "R7", "model sbox 01", STATE_W'(sbt[1]), 'h7c);
      check(sbt[8'h53] == 8'hed, "R7", "model sbox 53", STATE_W'(sbt[8'h53]), 'hed);

      repeat (3) @(negedge clk);
      // R1 reset state
      check(busy == 1'b0, "R1", "busy in reset", STATE_W'(busy), 0);
      check(done == 1'b0, "R1", "done in reset", STATE_W'(done), 0);
      check(dout == '0, "R1", "state in reset", dout, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 1'b0 && dout == '0, "R1", "idle after reset", dout, '0);

      for (int t = 0; t < 30; t++) begin
         if (t == 0) v = '0;
         else if (t == 1) v = '1;
         else if (t == 2) for (int b = 0; b < 64; b++) v[8*b +: 8] = 8'(b);
         else for (int w = 0; w < 8; w++) begin
            lf ^= lf << 13; lf ^= lf >> 7; lf ^= lf << 17;
            v[64*w +: 64] = lf;
         end
         for (int q = 0; q < 2; q++) begin
            exp = ref_perm(v, q[0]);
            run_perm(v, q[0], (t % 5) == 4, got);
            if (q == 0) check(got == exp, "R5 R7 R8 R9 R11", "P result", got, exp);
            else        check(got == exp, "R6 R7 R8 R9 R11", "Q result", got, exp);
            if ((t % 5) == 4)
               check(got == exp, "R4", "result with stray start", got, exp);
            if (t % 7 == 3) begin
               for (int h = 0; h < 5; h++) begin
                  @(negedge clk);
                  din = ~din; sel_q = ~sel_q;
               end
               check(dout == exp, "R10", "held result", dout, exp);
            end
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule